// File: doc/BRIEF.md
# Contactless Receiver Phase Sequencer

This block steps a contactless reader's receive path through its phases once a receive operation is launched. A start pulse loads a programmable wait count that is decremented on each bit-clock enable; the last three counts warm up the analog receive path, and when the count runs out the block watches the signal strength. Decoding begins only when the strength is above a programmed floor.

Two framing modes exist. In the standard mode, the serial-to-parallel stage is enabled only after the decoder reports a start-of-frame, and an end-of-frame closes the reception. In the alternate mode, the first valid data bit enables the serial-to-parallel stage and frame delimiters are ignored. In both modes a drop of the signal below the floor ends the reception. At the end the block raises a sticky done flag and returns to idle. The analog front end, the symbol decoder, byte assembly and CRC checking sit outside this block.

Top module: `rx_phase_seq`

## Requirements
- R1: While the synchronous active-low reset is held, and on its release, the modem state is 0 (idle) and every enable output, the done flag and the idle-return pulse are low.
- R2: A start pulse in idle loads the programmed wait value. The counter decreases by one on each cycle with the bit-clock enable high. The modem state is 1 while the count is above 3. Monitoring is reached after exactly as many bit-clock enables as the loaded count.
- R3: While the count is 3, 2 or 1, the modem state is 2 and the prepare enable is high. It stays high on cycles without a bit-clock enable.
- R4: A programmed wait value below 3 is treated as 3. The block enters modem state 2 directly after start and needs three bit-clock enables to reach monitoring.
- R5: When the count reaches 0, the modem state is 3 and the monitor/decode enable is high. The state moves to 4 (decoding) only on a cycle where the strength is strictly greater than the minimum level. Equality keeps it in state 3.
- R6: In standard mode (mode input 1), the serial-to-parallel enable rises in decoding on the cycle after a start-of-frame pulse. A valid-bit pulse alone does not raise it.
- R7: In alternate mode (mode input 0), the serial-to-parallel enable rises in decoding on the cycle after the first valid-bit pulse. A start-of-frame pulse has no effect.
- R8: Decoding ends when the strength is strictly below the minimum level, or in standard mode when an end-of-frame pulse arrives after the start-of-frame. An end-of-frame pulse is ignored before the start-of-frame and in alternate mode. Equal strength does not end decoding.
- R9: On termination the modem state returns to 0, all enables drop, the done flag is set, and the idle-return output pulses high for exactly one cycle.
- R10: The done flag stays set until a clear pulse. If termination and clear coincide, the flag ends up set.
- R11: A start pulse while the modem state is not 0 is ignored.
- R12: The framing mode is captured at the accepted start pulse. Later changes of the mode input have no effect on the running reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse for a receive operation |
| bit_en_i | input | 1 | Bit-clock enable, one cycle per bit period |
| wait_val_i | input | WAIT_W | Programmed wait count |
| level_i | input | LVL_W | Current signal strength |
| min_level_i | input | LVL_W | Minimum signal level threshold |
| std_mode_i | input | 1 | 1 = standard framing with start/end of frame, 0 = alternate |
| sof_i | input | 1 | Decoder pulse: start-of-frame found |
| eof_i | input | 1 | Decoder pulse: end-of-frame found |
| bit_vld_i | input | 1 | Decoder pulse: data bit valid |
| irq_clr_i | input | 1 | Clears the done flag |
| prep_en_o | output | 1 | Analog prepare/activate enable |
| mon_en_o | output | 1 | Monitor/decode enable |
| s2p_en_o | output | 1 | Serial-to-parallel enable |
| modem_state_o | output | 3 | Phase code: 0 idle, 1 wait, 2 prepare, 3 monitor, 4 decode |
| done_irq_o | output | 1 | Sticky receive-done flag |
| idle_ret_o | output | 1 | One-cycle pulse on return to idle |

## Verification
The bench targets strength equal to the floor, both on entry to decoding and while decoding. A design that uses a non-strict compare would start decoding too early or end it too early. It programs wait values 0 and 200: a design without the floor clamp would reach monitoring after zero or wrapped counts, and an off-by-one counter would move between phases one bit-clock off. It sends end-of-frame before start-of-frame, sends delimiters in alternate mode, changes the mode mid-run, and issues a clear together with termination. A wrong design would stop early, follow the new mode, or lose the done flag.

// File: rtl/rxseq_pkg.sv
// Package: shared phase type and modem-state codes for the receive sequencer.
package rxseq_pkg;

    // Internal phase register encoding; wait and prepare share PH_COUNT.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_COUNT = 2'd1,
        PH_MON   = 2'd2,
        PH_DEC   = 2'd3
    } phase_e;

    // Externally visible modem-state codes.
    localparam logic [2:0] MS_IDLE = 3'd0;
    localparam logic [2:0] MS_WAIT = 3'd1;
    localparam logic [2:0] MS_PREP = 3'd2;
    localparam logic [2:0] MS_MON  = 3'd3;
    localparam logic [2:0] MS_DEC  = 3'd4;

    // Number of final counts reserved for analog warm-up; also the wait floor.
    localparam int WARM_CNT = 3;

endpackage

// File: rtl/rxseq_wait_ctr.sv
// Module: rxseq_wait_ctr
// Wait countdown paced by the bit-clock enable. Loads the programmed value,
// raised to the warm-up floor, and counts down to zero.
// Assumes: WAIT_W is wide enough to hold WARM_CNT (at least 2 bits).
module rxseq_wait_ctr
    import rxseq_pkg::*;
#(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WAIT_W-1:0] wait_i,
    input  logic              dec_i,
    output logic              warm_o,
    output logic              last_o
);

    localparam logic [WAIT_W-1:0] FLOOR = WAIT_W'(WARM_CNT);
    localparam logic [WAIT_W-1:0] ONE   = WAIT_W'(1);

    logic [WAIT_W-1:0] cnt_q;
    logic [WAIT_W-1:0] load_val;

    // Clamp the programmed value up to the warm-up floor.
    always_comb begin
        load_val = (wait_i < FLOOR) ? FLOOR : wait_i;
    end

    // Count register: load on start, step down on each enabled bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Decode the warm-up window and the final count.
    always_comb begin
        warm_o = (cnt_q != '0) && (cnt_q <= FLOOR);
        last_o = (cnt_q == ONE);
    end

endmodule

// File: rtl/rxseq_level_cmp.sv
// Module: rxseq_level_cmp
// Strict comparison of signal strength against the minimum level.
// Assumes: both operands are unsigned and of equal width.
module rxseq_level_cmp #(
    parameter int LVL_W = 4
) (
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] min_i,
    output logic             above_o,
    output logic             below_o
);

    // Equal strength is neither above nor below.
    always_comb begin
        above_o = level_i > min_i;
        below_o = level_i < min_i;
    end

endmodule

// File: rtl/rxseq_frame_gate.sv
// Module: rxseq_frame_gate
// Captures the framing mode at start and tracks when the serial-to-parallel
// stage may run: after start-of-frame (standard) or the first bit (alternate).
// Assumes: arm_i and active_i are never high in the same cycle.
module rxseq_frame_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic std_i,
    input  logic active_i,
    input  logic sof_i,
    input  logic vld_i,
    output logic std_q_o,
    output logic s2p_en_o
);

    logic std_q;
    logic open_q;
    logic open_evt;

    // Event that opens the data path in the captured mode.
    always_comb begin
        open_evt = active_i && (std_q ? sof_i : vld_i);
    end

    // Mode capture and open flag; both restart on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            std_q  <= 1'b0;
            open_q <= 1'b0;
        end else if (arm_i) begin
            std_q  <= std_i;
            open_q <= 1'b0;
        end else if (open_evt) begin
            open_q <= 1'b1;
        end
    end

    // The enable only shows while decoding is active.
    always_comb begin
        std_q_o  = std_q;
        s2p_en_o = active_i && open_q;
    end

endmodule

// File: rtl/rxseq_done_flag.sv
// Module: rxseq_done_flag
// Sticky done flag with clear-on-pulse; set takes priority over clear.
// Assumes: set_i and clr_i are single-cycle pulses.
module rxseq_done_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // Hold the flag until cleared, giving priority to a new set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/rx_phase_seq.sv
// Module: rx_phase_seq
// Top of the receive phase sequencer: idle -> wait countdown (with warm-up
// on the last three counts) -> monitor -> decode -> idle.
// Assumes: decoder pulses are one cycle wide and synchronous to clk.
module rx_phase_seq
    import rxseq_pkg::*;
#(
    parameter int WAIT_W = 8,
    parameter int LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              bit_en_i,
    input  logic [WAIT_W-1:0] wait_val_i,
    input  logic [LVL_W-1:0]  level_i,
    input  logic [LVL_W-1:0]  min_level_i,
    input  logic              std_mode_i,
    input  logic              sof_i,
    input  logic              eof_i,
    input  logic              bit_vld_i,
    input  logic              irq_clr_i,
    output logic              prep_en_o,
    output logic              mon_en_o,
    output logic              s2p_en_o,
    output logic [2:0]        modem_state_o,
    output logic              done_irq_o,
    output logic              idle_ret_o
);

    phase_e phase_q, phase_d;
    logic   start_ok;
    logic   cnt_dec;
    logic   cnt_warm;
    logic   cnt_last;
    logic   lvl_above;
    logic   lvl_below;
    logic   mode_std;
    logic   s2p_en;
    logic   dec_active;
    logic   term;
    logic   ret_q;

    rxseq_wait_ctr #(.WAIT_W(WAIT_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (start_ok),
        .wait_i (wait_val_i),
        .dec_i  (cnt_dec),
        .warm_o (cnt_warm),
        .last_o (cnt_last)
    );

    rxseq_level_cmp #(.LVL_W(LVL_W)) u_cmp (
        .level_i (level_i),
        .min_i   (min_level_i),
        .above_o (lvl_above),
        .below_o (lvl_below)
    );

    rxseq_frame_gate u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (start_ok),
        .std_i    (std_mode_i),
        .active_i (dec_active),
        .sof_i    (sof_i),
        .vld_i    (bit_vld_i),
        .std_q_o  (mode_std),
        .s2p_en_o (s2p_en)
    );

    rxseq_done_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (term),
        .clr_i  (irq_clr_i),
        .flag_o (done_irq_o)
    );

    // Qualify start, counter stepping and termination from the current phase.
    always_comb begin
        start_ok   = (phase_q == PH_IDLE) && start_i;
        cnt_dec    = (phase_q == PH_COUNT) && bit_en_i;
        dec_active = (phase_q == PH_DEC);
        term       = dec_active && (lvl_below || (mode_std && s2p_en && eof_i));
    end

    // Phase transition logic.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:  if (start_ok)             phase_d = PH_COUNT;
            PH_COUNT: if (cnt_dec && cnt_last)  phase_d = PH_MON;
            PH_MON:   if (lvl_above)            phase_d = PH_DEC;
            PH_DEC:   if (term)                 phase_d = PH_IDLE;
            default:                            phase_d = PH_IDLE;
        endcase
    end

    // Phase register and idle-return pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            ret_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            ret_q   <= term;
        end
    end

    // Visible outputs derived from the phase and the warm-up window.
    always_comb begin
        prep_en_o  = (phase_q == PH_COUNT) && cnt_warm;
        mon_en_o   = (phase_q == PH_MON) || (phase_q == PH_DEC);
        s2p_en_o   = s2p_en;
        idle_ret_o = ret_q;
        unique case (phase_q)
            PH_IDLE:  modem_state_o = MS_IDLE;
            PH_COUNT: modem_state_o = cnt_warm ? MS_PREP : MS_WAIT;
            PH_MON:   modem_state_o = MS_MON;
            PH_DEC:   modem_state_o = MS_DEC;
            default:  modem_state_o = MS_IDLE;
        endcase
    end

endmodule

// File: rtl/rx_phase_seq_chk.sv
// Module: rx_phase_seq_chk
// Port-level properties of the receive sequencer, bound to every instance.
module rx_phase_seq_chk #(
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             bit_en_i,
    input logic [LVL_W-1:0] level_i,
    input logic [LVL_W-1:0] min_level_i,
    input logic             sof_i,
    input logic             bit_vld_i,
    input logic             irq_clr_i,
    input logic             prep_en_o,
    input logic             s2p_en_o,
    input logic [2:0]       modem_state_o,
    input logic             done_irq_o,
    input logic             idle_ret_o
);

    AST_PREP_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prep_en_o) |-> ($past(bit_en_i) || $past(start_i))); // R3

    AST_DEC_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (modem_state_o == 3'd4 && $past(modem_state_o) == 3'd3)
        |-> $past(level_i > min_level_i)); // R5

    AST_S2P_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s2p_en_o) |-> $past(sof_i || bit_vld_i)); // R6

    AST_RET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_ret_o |=> !idle_ret_o); // R9

    AST_RET_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_ret_o |-> (modem_state_o == 3'd0 && done_irq_o)); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_irq_o) |-> $past(irq_clr_i)); // R10

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (modem_state_o == 3'd4 && start_i) |=> (modem_state_o inside {3'd0, 3'd4})); // R11

endmodule

bind rx_phase_seq rx_phase_seq_chk #(.LVL_W(LVL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .bit_en_i      (bit_en_i),
    .level_i       (level_i),
    .min_level_i   (min_level_i),
    .sof_i         (sof_i),
    .bit_vld_i     (bit_vld_i),
    .irq_clr_i     (irq_clr_i),
    .prep_en_o     (prep_en_o),
    .s2p_en_o      (s2p_en_o),
    .modem_state_o (modem_state_o),
    .done_irq_o    (done_irq_o),
    .idle_ret_o    (idle_ret_o)
);

// File: tb/rx_phase_seq_bench.sv
// Bench for rx_phase_seq: a vector table for a standard-mode reception,
// then directed tests for reset, clamp, alternate mode, mode capture,
// a long wait and clear/set collision.
module rx_phase_seq_bench;

    localparam int WAIT_W = 8;
    localparam int LVL_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start_i, bit_en_i, std_mode_i, sof_i, eof_i, bit_vld_i, irq_clr_i;
    logic [WAIT_W-1:0] wait_val_i;
    logic [LVL_W-1:0]  level_i, min_level_i;
    logic              prep_en_o, mon_en_o, s2p_en_o, done_irq_o, idle_ret_o;
    logic [2:0]        modem_state_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rx_phase_seq #(.WAIT_W(WAIT_W), .LVL_W(LVL_W)) u_rx_phase_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_en_i(bit_en_i),
        .wait_val_i(wait_val_i), .level_i(level_i), .min_level_i(min_level_i),
        .std_mode_i(std_mode_i), .sof_i(sof_i), .eof_i(eof_i), .bit_vld_i(bit_vld_i),
        .irq_clr_i(irq_clr_i), .prep_en_o(prep_en_o), .mon_en_o(mon_en_o),
        .s2p_en_o(s2p_en_o), .modem_state_o(modem_state_o), .done_irq_o(done_irq_o),
        .idle_ret_o(idle_ret_o)
    );

    typedef struct packed {
        logic       st;
        logic       be;
        logic [3:0] lv;
        logic       sof;
        logic       eof;
        logic       vld;
        logic       clr;
        logic [2:0] ms;
        logic       prep;
        logic       mon;
        logic       s2p;
        logic       irq;
        logic       ret;
    } vec_t;

    // Standard mode, wait 5, min level 4. Outputs expected after the edge.
    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 start
        '{1'b0,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 count 4
        '{1'b0,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,1'b0,1'b0,1'b0}, // R3 count 3
        '{1'b0,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,1'b0,1'b0,1'b0}, // R3 hold
        '{1'b0,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,1'b0,1'b0,1'b0}, // R3 count 2
        '{1'b0,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,1'b0,1'b0,1'b0}, // R3 count 1
        '{1'b0,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0, 3'd3,1'b0,1'b1,1'b0,1'b0,1'b0}, // R5 monitor
        '{1'b0,1'b0,4'd4,1'b0,1'b0,1'b0,1'b0, 3'd3,1'b0,1'b1,1'b0,1'b0,1'b0}, // R5 equal level
        '{1'b0,1'b0,4'd9,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b0,1'b1,1'b0,1'b0,1'b0}, // R5 decode
        '{1'b0,1'b0,4'd9,1'b0,1'b1,1'b0,1'b0, 3'd4,1'b0,1'b1,1'b0,1'b0,1'b0}, // R8 eof before sof
        '{1'b0,1'b0,4'd9,1'b0,1'b0,1'b1,1'b0, 3'd4,1'b0,1'b1,1'b0,1'b0,1'b0}, // R6 bit without sof
        '{1'b0,1'b0,4'd9,1'b1,1'b0,1'b0,1'b0, 3'd4,1'b0,1'b1,1'b1,1'b0,1'b0}, // R6 sof
        '{1'b0,1'b0,4'd4,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b0,1'b1,1'b1,1'b0,1'b0}, // R8 equal level
        '{1'b1,1'b0,4'd9,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b0,1'b1,1'b1,1'b0,1'b0}, // R11 busy start
        '{1'b0,1'b0,4'd9,1'b0,1'b1,1'b0,1'b0, 3'd0,1'b0,1'b0,1'b0,1'b1,1'b1}, // R9 eof ends
        '{1'b0,1'b0,4'd9,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R9 pulse over
        '{1'b0,1'b0,4'd9,1'b0,1'b0,1'b0,1'b1, 3'd0,1'b0,1'b0,1'b0,1'b0,1'b0}  // R10 clear
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic quiet();
        start_i = 0; bit_en_i = 0; sof_i = 0; eof_i = 0; bit_vld_i = 0; irq_clr_i = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; quiet(); wait_val_i = 8'd5; level_i = 0; min_level_i = 4'd4; std_mode_i = 1;
        start_i = 1;
        repeat (3) step();
        chk("R1 state", modem_state_o, 0);
        chk("R1 enables", {prep_en_o, mon_en_o, s2p_en_o}, 0);
        chk("R1 flags", {done_irq_o, idle_ret_o}, 0);
        start_i = 0;
        rst_n = 1;
        step();
        chk("R1 after release", modem_state_o, 0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            start_i = VEC[i].st; bit_en_i = VEC[i].be; level_i = VEC[i].lv;
            sof_i = VEC[i].sof; eof_i = VEC[i].eof; bit_vld_i = VEC[i].vld; irq_clr_i = VEC[i].clr;
            step();
            chk($sformatf("vec %0d state", i), modem_state_o, VEC[i].ms);
            chk($sformatf("vec %0d prep", i), prep_en_o, VEC[i].prep);
            chk($sformatf("vec %0d mon", i), mon_en_o, VEC[i].mon);
            chk($sformatf("vec %0d s2p", i), s2p_en_o, VEC[i].s2p);
            chk($sformatf("vec %0d irq", i), done_irq_o, VEC[i].irq);
            chk($sformatf("vec %0d ret", i), idle_ret_o, VEC[i].ret);
        end
        quiet();

        // R4 clamp and R7 alternate mode.
        wait_val_i = 8'd0; std_mode_i = 0; level_i = 0; start_i = 1;
        step(); quiet();
        chk("R4 clamp enters prepare", modem_state_o, 2);
        chk("R4 prepare enable", prep_en_o, 1);
        bit_en_i = 1; step(); step();
        chk("R4 two steps still prepare", modem_state_o, 2);
        step(); bit_en_i = 0;
        chk("R4 third step monitors", modem_state_o, 3);
        level_i = 4'd9; step();
        chk("R5 decode alt", modem_state_o, 4);
        sof_i = 1; step(); sof_i = 0;
        chk("R7 sof ignored", s2p_en_o, 0);
        eof_i = 1; step(); eof_i = 0;
        chk("R8 eof ignored alt", modem_state_o, 4);
        bit_vld_i = 1; step(); bit_vld_i = 0;
        chk("R7 first bit opens", s2p_en_o, 1);
        level_i = 4'd2; irq_clr_i = 1; step(); irq_clr_i = 0;
        chk("R8 level drop ends", modem_state_o, 0);
        chk("R10 set beats clear", done_irq_o, 1);
        chk("R9 ret pulse", idle_ret_o, 1);
        step();
        chk("R10 flag held", done_irq_o, 1);

        // R12 mode captured at start.
        wait_val_i = 8'd3; std_mode_i = 1; level_i = 0; start_i = 1;
        step(); quiet(); std_mode_i = 0;
        bit_en_i = 1; repeat (3) step(); bit_en_i = 0;
        level_i = 4'd9; step();
        chk("R12 decode", modem_state_o, 4);
        bit_vld_i = 1; step(); bit_vld_i = 0;
        chk("R12 still standard", s2p_en_o, 0);
        sof_i = 1; step(); sof_i = 0;
        chk("R12 sof opens", s2p_en_o, 1);
        eof_i = 1; step(); eof_i = 0;
        chk("R12 eof ends", modem_state_o, 0);

        // R2 long wait.
        irq_clr_i = 1; step(); irq_clr_i = 0;
        chk("R10 clear", done_irq_o, 0);
        wait_val_i = 8'd200; start_i = 1; level_i = 0;
        step(); quiet();
        bit_en_i = 1;
        repeat (196) step();
        chk("R2 count 4 waits", modem_state_o, 1);
        step();
        chk("R3 count 3 prepares", modem_state_o, 2);
        step(); step();
        chk("R2 count 1", modem_state_o, 2);
        step(); bit_en_i = 0;
        chk("R2 monitor after 200", modem_state_o, 3);

        // R1 reset mid-run.
        rst_n = 0; step(); rst_n = 1;
        chk("R1 reset mid-run", modem_state_o, 0);
        chk("R1 reset mon", mon_en_o, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule